// File: doc/BRIEF.md
# Paged Qubit Command Decoder

This block takes fixed-size 64-bit quantum control command words, one per accepted valid/ready transfer, and turns them into decoded gate requests. Each word is split into a 12-bit opcode, a 16-bit argument and one or two 10-bit relative qubit indices. A small set of control opcodes does not produce a gate. Two of them load persistent page registers, one for each qubit lane. A third one opens a new session, which sets both page registers back to zero.

Every gate command leaves the block one clock after acceptance. It carries the full 46-bit absolute address of each qubit it touches. The address is the lane's page register placed above the relative index. The opcode's top bit tells single-qubit from dual-qubit commands. Unknown control opcodes raise a one-cycle error pulse.

A short-opcode mode is available through a parameter and is on by default. In this mode, a clear long-opcode flag bit masks the opcode bits between the short width and that flag, so short codes decode through a narrow table.

Top module: `qcmd_page_decoder`

## Requirements
- R1: A command word is split into the opcode in bits 63..52, the argument in bits 51..36, the page value in bits 35..0, the lane-0 relative index in bits 9..0 and the lane-1 relative index in bits 19..10.
- R2: The decoded outputs and the error pulse appear in the clock cycle right after the word is accepted. A cycle with no accepted word gives `out_valid` = 0 and `out_illegal` = 0 in the following cycle.
- R3: Effective opcode 0x002 loads the lane-0 page register from bits 35..0, and 0x003 loads the lane-1 page register the same way. Each page register keeps its value until it is written again.
- R4: Effective opcode 0x001 (session start) clears both page registers to zero.
- R5: A gate's lane address is (page << 10) + relative index, 46 bits wide.
- R6: A page write is already in force for the very next accepted word.
- R7: Opcode bit 11 set means a dual-qubit command, and bit 11 clear with an effective opcode of 0x010 or above means a single-qubit command. For a single-qubit command, `out_q1_addr` is zero and bits 19..10 of the word have no effect.
- R8: An effective opcode below 0x010 other than 0x001, 0x002 and 0x003 gives `out_illegal` = 1 for one cycle, no gate output and no page change.
- R9: When opcode bit 10 is clear, opcode bits 9..8 are treated as zero, both for decoding and for the reported `out_opcode`. When bit 10 is set, all 12 bits count.
- R10: Control opcodes 0x001, 0x002 and 0x003 produce neither a gate output nor an error.
- R11: A synchronous active-high reset clears both page registers, `out_valid` and `out_illegal`.
- R12: `in_ready` is 0 while reset is asserted and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 64 | Command word |
| out_valid | output | 1 | Decoded gate command present |
| out_dual | output | 1 | Gate uses both qubit lanes |
| out_opcode | output | 12 | Effective opcode |
| out_arg | output | 16 | Gate argument |
| out_q0_addr | output | 46 | Absolute address, qubit lane 0 |
| out_q1_addr | output | 46 | Absolute address, qubit lane 1 (zero for single-qubit) |
| out_illegal | output | 1 | One-cycle unknown-control-opcode pulse |

## Verification
The properties take `rst` to be synchronous, and they take any 64-bit pattern on `in_word` as legal whenever `in_valid` is high. No opcode or field combination is excluded. The stimulus holds each word for exactly one accepted cycle and drops `in_valid` in between, which lets the one-cycle latency property see idle cycles. It walks every one of the 4096 opcode values with pseudo-random payloads, so page loads, session starts, masked short codes and illegal codes all reach the page registers in varied orders.

// File: rtl/qcmd_pkg.sv
package qcmd_pkg;

   localparam int OPC_START  = 1;
   localparam int OPC_PAGE0  = 2;
   localparam int OPC_PAGE1  = 3;
   localparam int CTRL_LIMIT = 16;
   localparam int NUM_LANES  = 2;

   typedef enum logic [2:0] {
      CK_START,
      CK_PAGE0,
      CK_PAGE1,
      CK_ILLEGAL,
      CK_SINGLE,
      CK_DUAL
   } cmd_kind_e;

endpackage

// File: rtl/qcmd_field_split.sv
module qcmd_field_split
   import qcmd_pkg::*;
#(
   parameter int WORD_W       = 64,
   parameter int OP_W         = 12,
   parameter int ARG_W        = 16,
   parameter int PAGE_W       = 36,
   parameter int REL_W        = 10,
   parameter bit LONG_FLAG_EN = 1'b1,
   parameter int LONG_BIT     = 10,
   parameter int SHORT_W      = 8
) (
   input  logic [WORD_W-1:0] word,
   output logic [OP_W-1:0]   op_eff,
   output cmd_kind_e         kind,
   output logic [ARG_W-1:0]  arg,
   output logic [PAGE_W-1:0] page,
   output logic [REL_W-1:0]  rel0,
   output logic [REL_W-1:0]  rel1
);

   localparam int OP_LSB  = WORD_W - OP_W;
   localparam int ARG_LSB = OP_LSB - ARG_W;

   logic [OP_W-1:0] op_raw;

   // R1: fixed field positions
   assign op_raw = word[WORD_W-1:OP_LSB];
   assign arg    = word[OP_LSB-1:ARG_LSB];
   assign page   = word[PAGE_W-1:0];
   assign rel0   = word[REL_W-1:0];
   assign rel1   = word[2*REL_W-1:REL_W];

   // R9: short-opcode masking variant
   generate
      if (LONG_FLAG_EN) begin : g_short_mask
         for (genvar b = 0; b < OP_W; b++) begin : g_bit
            if (b >= SHORT_W && b < LONG_BIT) begin : g_masked
               assign op_eff[b] = op_raw[b] & op_raw[LONG_BIT];
            end else begin : g_kept
               assign op_eff[b] = op_raw[b];
            end
         end
      end else begin : g_full
         assign op_eff = op_raw;
      end
   endgenerate

   // R7, R8, R10: classification
   always_comb begin
      if (op_eff[OP_W-1]) begin
         kind = CK_DUAL;
      end else if (op_eff < OP_W'(CTRL_LIMIT)) begin
         if (op_eff == OP_W'(OPC_START))      kind = CK_START;
         else if (op_eff == OP_W'(OPC_PAGE0)) kind = CK_PAGE0;
         else if (op_eff == OP_W'(OPC_PAGE1)) kind = CK_PAGE1;
         else                                 kind = CK_ILLEGAL;
      end else begin
         kind = CK_SINGLE;
      end
   end

endmodule

// File: rtl/qcmd_page_bank.sv
module qcmd_page_bank #(
   parameter int PAGE_W    = 36,
   parameter int NUM_LANES = 2
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               clr,
   input  logic [NUM_LANES-1:0]               wr_en,
   input  logic [PAGE_W-1:0]                  wr_data,
   output logic [NUM_LANES-1:0][PAGE_W-1:0]   pages
);

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         always_ff @(posedge clk) begin
            if (rst || clr) begin
               pages[i] <= '0;
            end else if (wr_en[i]) begin
               pages[i] <= wr_data;
            end
         end

         p_page_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (!wr_en[i] && !clr) |=> $stable(pages[i]))
            else $error("page %0d changed without write", i);

         p_page_load_r6: assert property (@(posedge clk) disable iff (rst)
            (wr_en[i] && !clr) |=> (pages[i] == $past(wr_data)))
            else $error("page %0d load lost", i);

         p_start_clears_r4: assert property (@(posedge clk) disable iff (rst)
            clr |=> (pages[i] == '0))
            else $error("page %0d not cleared", i);
      end
   endgenerate

endmodule

// File: rtl/qcmd_addr_join.sv
module qcmd_addr_join #(
   parameter int PAGE_W    = 36,
   parameter int REL_W     = 10,
   parameter int NUM_LANES = 2
) (
   input  logic [NUM_LANES-1:0][PAGE_W-1:0]       pages,
   input  logic [NUM_LANES-1:0][REL_W-1:0]        rels,
   input  logic [NUM_LANES-1:0]                   lane_en,
   output logic [NUM_LANES-1:0][PAGE_W+REL_W-1:0] addrs
);

   // R5: page shifted above the relative index; the index fits below it,
   // so the sum is a concatenation
   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         assign addrs[i] = lane_en[i] ? {pages[i], rels[i]} : '0;
      end
   endgenerate

endmodule

// File: rtl/qcmd_page_decoder.sv
module qcmd_page_decoder
   import qcmd_pkg::*;
#(
   parameter int WORD_W       = 64,
   parameter int OP_W         = 12,
   parameter int ARG_W        = 16,
   parameter int PAGE_W       = 36,
   parameter int REL_W        = 10,
   parameter bit LONG_FLAG_EN = 1'b1,
   parameter int LONG_BIT     = 10,
   parameter int SHORT_W      = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [WORD_W-1:0]       in_word,
   output logic                    out_valid,
   output logic                    out_dual,
   output logic [OP_W-1:0]         out_opcode,
   output logic [ARG_W-1:0]        out_arg,
   output logic [PAGE_W+REL_W-1:0] out_q0_addr,
   output logic [PAGE_W+REL_W-1:0] out_q1_addr,
   output logic                    out_illegal
);

   localparam int ADDR_W = PAGE_W + REL_W;

   generate
      if (WORD_W != OP_W + ARG_W + PAGE_W) begin : g_bad_word
         $error("word width must equal opcode + argument + page widths");
      end
      if (2 * REL_W > PAGE_W) begin : g_bad_rel
         $error("both relative indices must sit inside the page field");
      end
      if (LONG_FLAG_EN && (LONG_BIT >= OP_W - 1 || LONG_BIT < SHORT_W)) begin : g_bad_long
         $error("long flag must sit between short width and dual bit");
      end
   endgenerate

   logic                              accept;
   logic [OP_W-1:0]                   op_eff;
   cmd_kind_e                         kind;
   logic [ARG_W-1:0]                  arg;
   logic [PAGE_W-1:0]                 page_val;
   logic [REL_W-1:0]                  rel0;
   logic [REL_W-1:0]                  rel1;
   logic [NUM_LANES-1:0][PAGE_W-1:0]  pages;
   logic [NUM_LANES-1:0][ADDR_W-1:0]  addrs;
   logic [NUM_LANES-1:0]              wr_en;
   logic                              clr;
   logic                              is_gate;

   assign in_ready = !rst;               // R12
   assign accept   = in_valid && in_ready;
   assign is_gate  = (kind == CK_SINGLE) || (kind == CK_DUAL);
   assign clr      = accept && (kind == CK_START);
   assign wr_en    = {accept && (kind == CK_PAGE1), accept && (kind == CK_PAGE0)};

   qcmd_field_split #(
      .WORD_W(WORD_W), .OP_W(OP_W), .ARG_W(ARG_W), .PAGE_W(PAGE_W),
      .REL_W(REL_W), .LONG_FLAG_EN(LONG_FLAG_EN), .LONG_BIT(LONG_BIT),
      .SHORT_W(SHORT_W)
   ) u_split (
      .word(in_word), .op_eff(op_eff), .kind(kind), .arg(arg),
      .page(page_val), .rel0(rel0), .rel1(rel1)
   );

   qcmd_page_bank #(.PAGE_W(PAGE_W), .NUM_LANES(NUM_LANES)) u_bank (
      .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en),
      .wr_data(page_val), .pages(pages)
   );

   qcmd_addr_join #(.PAGE_W(PAGE_W), .REL_W(REL_W), .NUM_LANES(NUM_LANES)) u_join (
      .pages(pages), .rels({rel1, rel0}), .lane_en({kind == CK_DUAL, 1'b1}),
      .addrs(addrs)
   );

   // R2, R11: one register stage after acceptance
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_dual    <= 1'b0;
         out_opcode  <= '0;
         out_arg     <= '0;
         out_q0_addr <= '0;
         out_q1_addr <= '0;
      end else begin
         out_valid   <= accept && is_gate;
         out_illegal <= accept && (kind == CK_ILLEGAL);
         if (accept && is_gate) begin
            out_dual    <= (kind == CK_DUAL);
            out_opcode  <= op_eff;
            out_arg     <= arg;
            out_q0_addr <= addrs[0];
            out_q1_addr <= addrs[1];
         end
      end
   end

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_illegal))
      else $error("output without accepted word");

   p_dual_flag_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_dual == out_opcode[OP_W-1]))
      else $error("dual flag disagrees with opcode");

   p_single_q1_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_dual) |-> (out_q1_addr == '0))
      else $error("single-qubit command drove lane 1");

   p_err_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> !out_valid)
      else $error("error pulse together with gate");

   p_rel_low_bits_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_q0_addr[REL_W-1:0] == $past(in_word[REL_W-1:0])))
      else $error("lane 0 relative index lost");

   generate
      if (LONG_FLAG_EN) begin : g_mask_chk
         p_short_mask_r9: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_opcode[LONG_BIT]) |-> (out_opcode[LONG_BIT-1:SHORT_W] == '0))
            else $error("short opcode not masked");
      end
   endgenerate

endmodule

// File: tb/qcmd_page_decoder_bench.sv
`timescale 1ns/1ps
module qcmd_page_decoder_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_word = '0;
   logic        out_valid, out_dual, out_illegal;
   logic [11:0] out_opcode;
   logic [15:0] out_arg;
   logic [45:0] out_q0_addr, out_q1_addr;

   int   n_checks = 0;
   int   n_err    = 0;
   bit   done     = 1'b0;

   logic [35:0] m_page0 = '0;
   logic [35:0] m_page1 = '0;
   logic [63:0] lfsr    = 64'h1234_5678_9ABC_DEF1;

   always #4 clk = ~clk;   // 125 MHz

   qcmd_page_decoder u_qcmd_page_decoder (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .out_valid(out_valid), .out_dual(out_dual),
      .out_opcode(out_opcode), .out_arg(out_arg), .out_q0_addr(out_q0_addr),
      .out_q1_addr(out_q1_addr), .out_illegal(out_illegal)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // R9: short-opcode masking
   function automatic logic [11:0] eff_op(input logic [11:0] op);
      logic [11:0] e;
      e = op;
      if (!op[10]) e[9:8] = 2'b00;
      return e;
   endfunction

   task automatic send(input logic [63:0] w);
      logic [11:0] e;
      logic        gate, dual, illegal;
      logic [45:0] q0, q1;
      e       = eff_op(w[63:52]);
      dual    = e[11];
      gate    = dual || (e >= 12'h010);
      illegal = !gate && !(e == 12'h001 || e == 12'h002 || e == 12'h003);
      q0      = {m_page0, w[9:0]};
      q1      = dual ? {m_page1, w[19:10]} : 46'h0;
      if (!gate) begin
         if (e == 12'h001) begin m_page0 = '0; m_page1 = '0; end
         else if (e == 12'h002) m_page0 = w[35:0];
         else if (e == 12'h003) m_page1 = w[35:0];
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 R10", "out_valid", 64'(out_valid), 64'(gate));
      chk("R8", "out_illegal", 64'(out_illegal), 64'(illegal));
      if (gate) begin
         chk("R7", "out_dual", 64'(out_dual), 64'(dual));
         chk("R9", "out_opcode", 64'(out_opcode), 64'(e));
         chk("R1", "out_arg", 64'(out_arg), 64'(w[51:36]));
         chk("R5 R6", "out_q0_addr", 64'(out_q0_addr), 64'(q0));
         chk("R7 R5", "out_q1_addr", 64'(out_q1_addr), 64'(q1));
      end
   endtask

   task automatic idle_check();
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R2", "idle out_valid", 64'(out_valid), 64'h0);
      chk("R2", "idle out_illegal", 64'(out_illegal), 64'h0);
   endtask

   initial begin
      in_word = 64'hFFFF_FFFF_FFFF_FFFF;
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11", "reset out_valid", 64'(out_valid), 64'h0);
      chk("R11", "reset out_illegal", 64'(out_illegal), 64'h0);
      chk("R12", "reset in_ready", 64'(in_ready), 64'h0);
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      chk("R12", "in_ready after reset", 64'(in_ready), 64'h1);

      // R11: pages start at zero
      send({12'h045, 16'hBEEF, 36'h0_0000_0155});
      // R3, R6: load both pages, next word uses them
      send({12'h002, 16'h0000, 36'h9_ABCD_1234});
      send({12'h003, 16'h0000, 36'hF_FFFF_FFFF});
      send({12'h845, 16'h1234, 16'h0000, 10'h001, 10'h3FF});
      // R7: single command ignores bits 19..10
      send({12'h045, 16'h5555, 16'h0000, 10'h3FF, 10'h000});
      // R8: illegal codes leave pages untouched
      send({12'h000, 16'h0000, 36'h0_0000_0000});
      send({12'h00F, 16'h0000, 36'h1_1111_1111});
      send({12'h8FF, 16'hFFFF, 16'h0000, 10'h3FF, 10'h3FF});
      // R9: bits 9..8 masked when bit 10 clear; kept when set
      send({12'h302, 16'h0000, 36'h5_0505_0505});
      send({12'h502, 16'h7777, 36'h0_0000_0002});
      send({12'h845, 16'h0001, 16'h0000, 10'h2AA, 10'h155});
      // R4: session start clears both pages
      send({12'h101, 16'h0000, 36'hA_AAAA_AAAA});
      send({12'h9FF, 16'h0002, 16'h0000, 10'h123, 10'h321});
      idle_check();

      // Exhaustive opcode sweep with pseudo-random payloads
      for (int op = 0; op < 4096; op++) begin
         lfsr = lfsr * 64'd6364136223846793005 + 64'd1442695040888963407;
         send({op[11:0], lfsr[51:0]});
         if (op % 512 == 0) idle_check();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

endmodule